// File: doc/BRIEF.md
# Pipelined Edge Deblocking Filter

This block smooths one line of eight pixels that straddles a block boundary in a reconstructed video picture. Four pixels sit on the P side of the boundary and four on the Q side. Each side arrives as one 32-bit word, with the pixel nearest the boundary in the low byte. The caller also supplies a boundary strength, two activity thresholds (`alpha`, `beta`) and a clipping base. From these the block picks one of three treatments: leave the line alone, apply a small clipped correction, or replace the pixels near the boundary with short weighted averages.

The work is split over three register stages. Stage one measures pixel differences, decides the mode and derives the clipping limit. Stage two forms the correction terms and the shared partial sums of the averaging filter. Stage three selects the final pixels and saturates them. A new line can be accepted every cycle. A valid flag travels alongside each line, so results leave in input order after a fixed delay. A mode input chooses luminance or chrominance rules. In chrominance mode only the two pixels next to the boundary can change.

Top module: `dbk_edge_filter`

## Requirements
- R1: Byte k of `p_word` is pixel p_k and byte k of `q_word` is pixel q_k, where byte 0 is bits 7:0 and index 0 is nearest the boundary. With strength 0 or 5..7 both words come out unchanged.
- R2: `out_valid` is high exactly three clock cycles after `in_valid` was sampled high, and at no other time. Lines leave in the order they entered.
- R3: A line is modified only when |p0-q0| < alpha, |p1-p0| < beta and |q1-q0| < beta. Otherwise it comes out unchanged for every strength.
- R4: For strength 1..3 in luminance mode, let delta = ((4(q0-p0) + p1 - q1 + 4) >> 3), using arithmetic shift. Delta is clipped to ±tc, where tc = clip_base + (|p2-p0| < beta) + (|q2-q0| < beta). Then p0 becomes p0+delta and q0 becomes q0-delta, each saturated to 0..255.
- R5: For strength 1..3 in luminance mode, p1 changes only when |p2-p0| < beta. It becomes p1 plus clip(±clip_base, (p2 + ((p0+q0+1)>>1) - 2p1) >> 1). q1 follows the same rule with the Q-side pixels. p2 and q2 never change under this filter.
- R6: For strength 1..3 in chrominance mode, tc = clip_base + 1. Only p0 and q0 change.
- R7: For strength 4 in luminance mode, the P side is replaced when |p2-p0| < beta and |p0-q0| < (alpha>>2)+2. The new values are p0 = (p2+2p1+2p0+2q0+q1+4)>>3, p1 = (p2+p1+p0+q0+2)>>2 and p2 = (2p3+3p2+p1+p0+q0+4)>>3. The Q side is handled in the same way.
- R8: For strength 4 in luminance mode, a side that fails the R7 test changes only its nearest pixel, to (2p1+p0+q1+2)>>2 (or the Q-side equivalent).
- R9: For strength 4 in chrominance mode, only p0 and q0 change, each by the rule of R8.
- R10: p3 and q3 always come out unchanged.
- R11: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A line is presented this cycle |
| chroma_mode | input | 1 | 1 selects chrominance rules |
| strength | input | 3 | Boundary strength, 0..7 |
| alpha | input | 8 | Threshold on the step across the boundary |
| beta | input | 8 | Threshold on the steps within one side |
| clip_base | input | 5 | Base clipping limit for the weak filter |
| p_word | input | 32 | P-side pixels, p0 in bits 7:0 |
| q_word | input | 32 | Q-side pixels, q0 in bits 7:0 |
| out_valid | output | 1 | Filtered line is present |
| p_out | output | 32 | Filtered P-side pixels, same packing |
| q_out | output | 32 | Filtered Q-side pixels, same packing |

## Verification
The assertions assume that the inputs are known whenever `in_valid` is high. They also assume `clip_base` stays below 32, which its 5-bit width already guarantees. The latency property assumes reset is held long enough to clear all three stages. The stimulus keeps `in_valid` low during reset and drives every input at the falling edge. Random lines are built from a base pixel plus small offsets, so values stay in 0..255 while still reaching every mode, both clip limits and both outcomes of the strong-side test.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
    localparam int PIX_W = 8;
    localparam int TAPS  = 4;
    localparam int BUS_W = PIX_W * TAPS;
    localparam int STR_W = 3;
    localparam int C1_W  = 5;
    localparam int TC_W  = C1_W + 2;
    localparam int SW    = PIX_W + 4;

    localparam logic signed [SW-1:0] S_ONE  = SW'(1);
    localparam logic signed [SW-1:0] S_FOUR = SW'(4);
    localparam logic [SW-1:0]        U_TWO  = SW'(2);
    localparam logic [SW-1:0]        U_FOUR = SW'(4);

    typedef logic [PIX_W-1:0]            pix_t;
    typedef logic [TAPS-1:0][PIX_W-1:0]  side_t;
    typedef logic signed [SW-1:0]        sw_t;
    typedef enum logic [1:0] {FM_NONE, FM_WEAK, FM_STRONG} fmode_t;

    typedef struct packed {
        logic              v;
        logic              chroma;
        fmode_t            mode;
        side_t             p;
        side_t             q;
        logic              p_near;
        logic              q_near;
        logic              p_strong;
        logic              q_strong;
        logic [C1_W-1:0]   c1;
        logic [TC_W-1:0]   tc;
    } dec_t;

    typedef struct packed {
        logic              v;
        logic              chroma;
        fmode_t            mode;
        side_t             p;
        side_t             q;
        logic              p_near;
        logic              q_near;
        logic              p_strong;
        logic              q_strong;
        logic [TC_W-1:0]   tc;
        sw_t               d0;
        sw_t               dp1;
        sw_t               dq1;
        pix_t              sp0, sp1, sp2, tp0;
        pix_t              sq0, sq1, sq2, tq0;
    } ar_t;

    typedef struct packed {
        logic  v;
        side_t p;
        side_t q;
    } out_t;

    function automatic pix_t absd(pix_t a, pix_t b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic sw_t to_s(pix_t x);
        return $signed({{(SW-PIX_W){1'b0}}, x});
    endfunction

    function automatic logic [SW-1:0] zx(pix_t x);
        return {{(SW-PIX_W){1'b0}}, x};
    endfunction

    function automatic sw_t clip_s(sw_t x, sw_t lim);
        if (x > lim)  return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

    function automatic pix_t sat_pix(sw_t x);
        if (x[SW-1])             return '0;
        if (|x[SW-2:PIX_W])      return '1;
        return x[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/dbk_stage_decide.sv
module dbk_stage_decide
    import dbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              chroma_mode,
    input  logic [STR_W-1:0]  strength,
    input  pix_t              alpha,
    input  pix_t              beta,
    input  logic [C1_W-1:0]   clip_base,
    input  logic [BUS_W-1:0]  p_word,
    input  logic [BUS_W-1:0]  q_word,
    output dec_t              dec_q
);
    dec_t dec_d;
    pix_t gap_pq, step_p, step_q, reach_p, reach_q;
    logic samples_ok, near_gap;

    always_comb begin
        dec_d        = '0;
        dec_d.v      = in_valid;
        dec_d.chroma = chroma_mode;
        dec_d.p      = side_t'(p_word);
        dec_d.q      = side_t'(q_word);
        dec_d.c1     = clip_base;

        gap_pq  = absd(dec_d.p[0], dec_d.q[0]);
        step_p  = absd(dec_d.p[1], dec_d.p[0]);
        step_q  = absd(dec_d.q[1], dec_d.q[0]);
        reach_p = absd(dec_d.p[2], dec_d.p[0]);
        reach_q = absd(dec_d.q[2], dec_d.q[0]);

        samples_ok = (gap_pq < alpha) && (step_p < beta) && (step_q < beta);
        near_gap   = gap_pq < ((alpha >> 2) + PIX_W'(2));

        dec_d.p_near   = reach_p < beta;
        dec_d.q_near   = reach_q < beta;
        dec_d.p_strong = !chroma_mode && dec_d.p_near && near_gap;
        dec_d.q_strong = !chroma_mode && dec_d.q_near && near_gap;

        if (!samples_ok || strength == '0 || strength > STR_W'(4))
            dec_d.mode = FM_NONE;
        else if (strength == STR_W'(4))
            dec_d.mode = FM_STRONG;
        else
            dec_d.mode = FM_WEAK;

        if (chroma_mode)
            dec_d.tc = TC_W'(clip_base) + TC_W'(1);
        else
            dec_d.tc = TC_W'(clip_base) + TC_W'(dec_d.p_near) + TC_W'(dec_d.q_near);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end
endmodule

// File: rtl/dbk_stage_arith.sv
module dbk_stage_arith
    import dbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  dec_t dec_i,
    output ar_t  ar_q
);
    ar_t ar_d;
    sw_t p0s, p1s, p2s, q0s, q1s, q2s, raw0, avg, rp1, rq1, tcs, c1s;
    logic [SW-1:0] t_pq, a_p, a_q;
    logic [SW-1:0] wp0, wp1, wp2, wtp, wq0, wq1, wq2, wtq;

    always_comb begin
        ar_d          = '0;
        ar_d.v        = dec_i.v;
        ar_d.chroma   = dec_i.chroma;
        ar_d.mode     = dec_i.mode;
        ar_d.p        = dec_i.p;
        ar_d.q        = dec_i.q;
        ar_d.p_near   = dec_i.p_near;
        ar_d.q_near   = dec_i.q_near;
        ar_d.p_strong = dec_i.p_strong;
        ar_d.q_strong = dec_i.q_strong;
        ar_d.tc       = dec_i.tc;

        // weak path: signed correction terms
        p0s = to_s(dec_i.p[0]); p1s = to_s(dec_i.p[1]); p2s = to_s(dec_i.p[2]);
        q0s = to_s(dec_i.q[0]); q1s = to_s(dec_i.q[1]); q2s = to_s(dec_i.q[2]);
        tcs = $signed({{(SW-TC_W){1'b0}}, dec_i.tc});
        c1s = $signed({{(SW-C1_W){1'b0}}, dec_i.c1});

        raw0     = ((q0s - p0s) <<< 2) + (p1s - q1s) + S_FOUR;
        ar_d.d0  = clip_s(raw0 >>> 3, tcs);
        avg      = (p0s + q0s + S_ONE) >>> 1;
        rp1      = (p2s + avg - (p1s <<< 1)) >>> 1;
        rq1      = (q2s + avg - (q1s <<< 1)) >>> 1;
        ar_d.dp1 = clip_s(rp1, c1s);
        ar_d.dq1 = clip_s(rq1, c1s);

        // strong path: shared partial sums
        t_pq = zx(dec_i.p[0]) + zx(dec_i.q[0]);
        a_p  = zx(dec_i.p[1]) + t_pq;
        a_q  = zx(dec_i.q[1]) + t_pq;

        wp1 = (zx(dec_i.p[2]) + a_p + U_TWO) >> 2;
        wp0 = (zx(dec_i.p[2]) + (a_p << 1) + zx(dec_i.q[1]) + U_FOUR) >> 3;
        wp2 = ((zx(dec_i.p[3]) << 1) + (zx(dec_i.p[2]) << 1) + zx(dec_i.p[2]) + a_p + U_FOUR) >> 3;
        wtp = ((zx(dec_i.p[1]) << 1) + zx(dec_i.p[0]) + zx(dec_i.q[1]) + U_TWO) >> 2;

        wq1 = (zx(dec_i.q[2]) + a_q + U_TWO) >> 2;
        wq0 = (zx(dec_i.q[2]) + (a_q << 1) + zx(dec_i.p[1]) + U_FOUR) >> 3;
        wq2 = ((zx(dec_i.q[3]) << 1) + (zx(dec_i.q[2]) << 1) + zx(dec_i.q[2]) + a_q + U_FOUR) >> 3;
        wtq = ((zx(dec_i.q[1]) << 1) + zx(dec_i.q[0]) + zx(dec_i.p[1]) + U_TWO) >> 2;

        ar_d.sp0 = wp0[PIX_W-1:0]; ar_d.sp1 = wp1[PIX_W-1:0];
        ar_d.sp2 = wp2[PIX_W-1:0]; ar_d.tp0 = wtp[PIX_W-1:0];
        ar_d.sq0 = wq0[PIX_W-1:0]; ar_d.sq1 = wq1[PIX_W-1:0];
        ar_d.sq2 = wq2[PIX_W-1:0]; ar_d.tq0 = wtq[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ar_q <= '0;
        else        ar_q <= ar_d;
    end
endmodule

// File: rtl/dbk_stage_select.sv
module dbk_stage_select
    import dbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ar_t  ar_i,
    output out_t out_q
);
    out_t out_d;

    always_comb begin
        out_d.v = ar_i.v;
        out_d.p = ar_i.p;
        out_d.q = ar_i.q;
        unique case (ar_i.mode)
            FM_WEAK: begin
                out_d.p[0] = sat_pix(to_s(ar_i.p[0]) + ar_i.d0);
                out_d.q[0] = sat_pix(to_s(ar_i.q[0]) - ar_i.d0);
                if (!ar_i.chroma && ar_i.p_near)
                    out_d.p[1] = sat_pix(to_s(ar_i.p[1]) + ar_i.dp1);
                if (!ar_i.chroma && ar_i.q_near)
                    out_d.q[1] = sat_pix(to_s(ar_i.q[1]) + ar_i.dq1);
            end
            FM_STRONG: begin
                if (ar_i.p_strong) begin
                    out_d.p[0] = ar_i.sp0;
                    out_d.p[1] = ar_i.sp1;
                    out_d.p[2] = ar_i.sp2;
                end else begin
                    out_d.p[0] = ar_i.tp0;
                end
                if (ar_i.q_strong) begin
                    out_d.q[0] = ar_i.sq0;
                    out_d.q[1] = ar_i.sq1;
                    out_d.q[2] = ar_i.sq2;
                end else begin
                    out_d.q[0] = ar_i.tq0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // R3: a line that was not selected for filtering leaves untouched
    p_samples_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.v && $past(ar_i.mode) == FM_NONE) |->
        (out_q.p == $past(ar_i.p) && out_q.q == $past(ar_i.q)));

    // R4: weak correction on p0 never exceeds the clip limit
    p_weak_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.v && $past(ar_i.mode) == FM_WEAK) |->
        (absd(out_q.p[0], $past(ar_i.p[0])) <= {{(PIX_W-TC_W){1'b0}}, $past(ar_i.tc)}));

    // R6, R9: chrominance lines keep all but the boundary pixels
    p_chroma_inner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.v && $past(ar_i.chroma)) |->
        (out_q.p[TAPS-1:1] == $past(ar_i.p[TAPS-1:1]) &&
         out_q.q[TAPS-1:1] == $past(ar_i.q[TAPS-1:1])));

    // R10: outermost pixels pass through
    p_outer_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.v |->
        (out_q.p[TAPS-1] == $past(ar_i.p[TAPS-1]) && out_q.q[TAPS-1] == $past(ar_i.q[TAPS-1])));
endmodule

// File: rtl/dbk_edge_filter.sv
module dbk_edge_filter
    import dbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              chroma_mode,
    input  logic [2:0]        strength,
    input  logic [7:0]        alpha,
    input  logic [7:0]        beta,
    input  logic [4:0]        clip_base,
    input  logic [31:0]       p_word,
    input  logic [31:0]       q_word,
    output logic              out_valid,
    output logic [31:0]       p_out,
    output logic [31:0]       q_out
);
    dec_t dec_s;
    ar_t  ar_s;
    out_t out_s;

    dbk_stage_decide u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .chroma_mode (chroma_mode),
        .strength    (strength),
        .alpha       (alpha),
        .beta        (beta),
        .clip_base   (clip_base),
        .p_word      (p_word),
        .q_word      (q_word),
        .dec_q       (dec_s)
    );

    dbk_stage_arith u_arith (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_i (dec_s),
        .ar_q  (ar_s)
    );

    dbk_stage_select u_select (
        .clk   (clk),
        .rst_n (rst_n),
        .ar_i  (ar_s),
        .out_q (out_s)
    );

    assign out_valid = out_s.v;
    assign p_out     = BUS_W'(out_s.p);
    assign q_out     = BUS_W'(out_s.q);

    // R2: fixed three-cycle delay in both directions
    p_latency_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    p_latency_bwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R11: reset clears the output flag
    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/dbk_edge_filter_tb.sv
module dbk_edge_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        chroma_mode = 1'b0;
    logic [2:0]  strength = '0;
    logic [7:0]  alpha = '0;
    logic [7:0]  beta = '0;
    logic [4:0]  clip_base = '0;
    logic [31:0] p_word = '0;
    logic [31:0] q_word = '0;
    logic        out_valid;
    logic [31:0] p_out, q_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          cyc;
        logic [31:0] ep, eq, ip, iq;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbk_edge_filter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chroma_mode(chroma_mode),
        .strength(strength), .alpha(alpha), .beta(beta), .clip_base(clip_base),
        .p_word(p_word), .q_word(q_word), .out_valid(out_valid),
        .p_out(p_out), .q_out(q_out)
    );

    function automatic int iabs(int x); return (x < 0) ? -x : x; endfunction
    function automatic int sat(int x); return (x < 0) ? 0 : (x > 255) ? 255 : x; endfunction
    function automatic int clp(int x, int l); return (x > l) ? l : (x < -l) ? -l : x; endfunction

    function automatic logic [31:0] pk(int a0, int a1, int a2, int a3);
        return {a3[7:0], a2[7:0], a1[7:0], a0[7:0]};
    endfunction

    function automatic logic [63:0] ref_model(int bs, int al, int be, int c1, bit ch,
                                              logic [31:0] pw, logic [31:0] qw);
        int p[4]; int q[4]; int np[4]; int nq[4];
        int ap, aq, tc, d, avg;
        for (int i = 0; i < 4; i++) begin
            p[i] = int'(pw[8*i +: 8]); q[i] = int'(qw[8*i +: 8]);
            np[i] = p[i]; nq[i] = q[i];
        end
        if (bs >= 1 && bs <= 4 && iabs(p[0]-q[0]) < al &&
            iabs(p[1]-p[0]) < be && iabs(q[1]-q[0]) < be) begin
            ap = iabs(p[2]-p[0]);
            aq = iabs(q[2]-q[0]);
            if (bs == 4) begin
                if (!ch && ap < be && iabs(p[0]-q[0]) < (al/4)+2) begin
                    np[0] = (p[2]+2*p[1]+2*p[0]+2*q[0]+q[1]+4)/8;
                    np[1] = (p[2]+p[1]+p[0]+q[0]+2)/4;
                    np[2] = (2*p[3]+3*p[2]+p[1]+p[0]+q[0]+4)/8;
                end else np[0] = (2*p[1]+p[0]+q[1]+2)/4;
                if (!ch && aq < be && iabs(p[0]-q[0]) < (al/4)+2) begin
                    nq[0] = (q[2]+2*q[1]+2*q[0]+2*p[0]+p[1]+4)/8;
                    nq[1] = (q[2]+q[1]+q[0]+p[0]+2)/4;
                    nq[2] = (2*q[3]+3*q[2]+q[1]+q[0]+p[0]+4)/8;
                end else nq[0] = (2*q[1]+q[0]+p[1]+2)/4;
            end else begin
                tc = ch ? c1 + 1 : c1 + int'(ap < be) + int'(aq < be);
                d  = clp(((q[0]-p[0])*4 + (p[1]-q[1]) + 4) >>> 3, tc);
                np[0] = sat(p[0] + d);
                nq[0] = sat(q[0] - d);
                avg = (p[0] + q[0] + 1) >>> 1;
                if (!ch && ap < be) np[1] = sat(p[1] + clp((p[2] + avg - 2*p[1]) >>> 1, c1));
                if (!ch && aq < be) nq[1] = sat(q[1] + clp((q[2] + avg - 2*q[1]) >>> 1, c1));
            end
        end
        return {pk(np[0], np[1], np[2], np[3]), pk(nq[0], nq[1], nq[2], nq[3])};
    endfunction

    task automatic drive(int bs, int al, int be, int c1, bit ch,
                         logic [31:0] pw, logic [31:0] qw, string tag);
        item_t it;
        logic [63:0] e;
        @(negedge clk);
        in_valid = 1'b1; strength = bs[2:0]; alpha = al[7:0]; beta = be[7:0];
        clip_base = c1[4:0]; chroma_mode = ch; p_word = pw; q_word = qw;
        e = ref_model(bs, al, be, c1, ch, pw, qw);
        it.cyc = cyc; it.ep = e[63:32]; it.eq = e[31:0]; it.ip = pw; it.iq = qw; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                item_t it;
                if (sbq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected out_valid: got 1 expected 0");
                end else begin
                    it = sbq.pop_front();
                    checks++;
                    if (cyc - it.cyc != 3) begin
                        errors++;
                        $display("FAIL R2 latency: got %0d expected 3", cyc - it.cyc);
                    end
                    checks++;
                    if (p_out !== it.ep || q_out !== it.eq) begin
                        errors++;
                        $display("FAIL %s data: got p=%h q=%h expected p=%h q=%h",
                                 it.tag, p_out, q_out, it.ep, it.eq);
                    end
                    checks++;
                    if (p_out[31:24] !== it.ip[31:24] || q_out[31:24] !== it.iq[31:24]) begin
                        errors++;
                        $display("FAIL R10 outer pixels: got %h/%h expected %h/%h",
                                 p_out[31:24], q_out[31:24], it.ip[31:24], it.iq[31:24]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R11 reset: got out_valid=%b expected 0", out_valid);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        drive(0, 40, 10, 3, 0, pk(80, 81, 82, 83), pk(86, 87, 88, 89), "R1");
        drive(6, 40, 10, 3, 0, pk(80, 81, 82, 83), pk(86, 87, 88, 89), "R1");
        drive(2, 40, 10, 3, 0, pk(10, 11, 12, 13), pk(100, 101, 102, 103), "R3");
        drive(4, 40, 10, 3, 0, pk(50, 70, 50, 50), pk(52, 52, 52, 52), "R3");
        drive(2, 40, 10, 1, 0, pk(60, 62, 63, 64), pk(70, 71, 72, 73), "R4");
        drive(3, 60, 10, 4, 0, pk(200, 205, 207, 99), pk(240, 236, 234, 17), "R4");
        drive(2, 40, 10, 1, 0, pk(60, 62, 80, 64), pk(70, 71, 72, 73), "R5");
        drive(1, 40, 10, 2, 0, pk(60, 64, 68, 64), pk(70, 65, 90, 73), "R5");
        drive(2, 40, 10, 1, 1, pk(60, 62, 63, 64), pk(70, 71, 72, 73), "R6");
        idle(1);
        drive(4, 40, 10, 0, 0, pk(100, 101, 102, 103), pk(104, 105, 106, 107), "R7");
        drive(4, 40, 10, 0, 0, pk(100, 96, 90, 250), pk(104, 108, 110, 3), "R7");
        drive(4, 20, 10, 0, 0, pk(100, 101, 102, 103), pk(110, 111, 112, 113), "R8");
        drive(4, 40, 10, 0, 0, pk(100, 101, 130, 103), pk(104, 105, 106, 107), "R8");
        drive(4, 40, 10, 0, 1, pk(100, 101, 102, 103), pk(104, 105, 106, 107), "R9");
        idle(3);

        for (int n = 0; n < 400; n++) begin
            int b0, bq;
            int pv[4]; int qv[4];
            b0 = int'($urandom_range(0, 255));
            bq = sat(b0 + int'($urandom_range(0, 60)) - 30);
            pv[0] = b0; qv[0] = bq;
            for (int i = 1; i < 4; i++) begin
                pv[i] = sat(pv[i-1] + int'($urandom_range(0, 16)) - 8);
                qv[i] = sat(qv[i-1] + int'($urandom_range(0, 16)) - 8);
            end
            drive(int'($urandom_range(0, 7)), int'($urandom_range(0, 80)),
                  int'($urandom_range(0, 20)), int'($urandom_range(0, 31)),
                  bit'($urandom_range(0, 1)),
                  pk(pv[0], pv[1], pv[2], pv[3]), pk(qv[0], qv[1], qv[2], qv[3]), "R4 R7 random");
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        idle(6);

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R2 missing outputs: got %0d pending expected 0", sbq.size());
        end
        finish_run();
    end
endmodule